// File: doc/BRIEF.md
# Ring Node Forwarding Arbiter

This block sits in one station of a one-way daisy-chain ring. Packets arrive from the upstream neighbour as a valid/ready stream of beats. Each first beat carries the originator's 8-bit station ID, a mark bit and an error flag. The block relays every packet that another station sent. It removes packets that this station originated, because they have completed the loop. It also discards packets flagged as corrupt, and it slips packets from the local transmit queue into the gaps on the downstream link. Relayed traffic always wins a free link, and a packet that has started on the link runs to its last beat without interruption.

The same logic watches for its own packets coming back. A clean returning own packet raises a ring-intact flag. The flag falls again when no own packet returns within a programmable number of cycles after the most recent local send. A marked local packet starts a cycle counter, and when a marked packet of this station comes back, the elapsed cycles are reported as a one-cycle latency result.

Top module: `ring_fwd_arbiter`

## Requirements
- R1: While reset is asserted and right after it, tx_valid, ring_ok, err_pulse and lat_valid are 0.
- R2: A packet whose first beat has rx_err=0 and rx_src different from node_id appears on the tx port with every beat unchanged (data, source, last, mark), in arrival order relative to other relayed packets.
- R3: A packet whose first beat has rx_err=0 and rx_src equal to node_id is accepted (rx_ready=1 on each of its beats) and none of its beats appear on tx.
- R4: A packet whose first beat has rx_err=1 is accepted and never appears on tx, and err_pulse is 1 for exactly the cycle after that first beat is accepted. The error flag on later beats is ignored.
- R5: When no packet is in progress on tx and a relayable first beat is presented, tx carries that beat and loc_ready is 0, even with loc_valid high.
- R6: Once a beat of a packet is offered on tx, tx carries only that packet until its last beat is accepted. rx_ready stays 0 for relayable beats during a local packet, and loc_ready stays 0 during a relayed one. Beats to be discarded are accepted at any time.
- R7: Local packets leave on tx in queue order with tx_src equal to node_id and data, last and mark unchanged.
- R8: ring_ok becomes 1 one cycle after the first beat of a clean own packet is accepted.
- R9: Let E be the clock edge that accepts the first beat of the latest local packet. If no clean own first beat is accepted after E, ring_ok becomes 0 at edge E+timeout_cfg+1.
- R10: Let S be the edge that accepts the first beat of a marked local packet, and R the next edge that accepts the first beat of a clean marked own packet. One cycle after R, lat_valid pulses for one cycle with lat_cycles = R-S, saturated at the all-ones value. A newer marked send restarts the measurement, including in the same cycle as a return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| node_id | input | ID_W | Static station ID |
| timeout_cfg | input | TO_W | Ring-intact timeout in cycles |
| rx_valid | input | 1 | Upstream beat valid |
| rx_ready | output | 1 | Upstream beat accepted |
| rx_data | input | DATA_W | Upstream payload |
| rx_src | input | ID_W | Originator ID (first beat) |
| rx_last | input | 1 | Last beat of packet |
| rx_err | input | 1 | Corrupt packet flag (first beat) |
| rx_mark | input | 1 | Latency mark (first beat) |
| loc_valid | input | 1 | Local beat valid |
| loc_ready | output | 1 | Local beat accepted |
| loc_data | input | DATA_W | Local payload |
| loc_last | input | 1 | Last local beat |
| loc_mark | input | 1 | Latency mark for local packet |
| tx_valid | output | 1 | Downstream beat valid |
| tx_ready | input | 1 | Downstream beat accepted |
| tx_data | output | DATA_W | Downstream payload |
| tx_src | output | ID_W | Originator ID |
| tx_last | output | 1 | Last beat |
| tx_mark | output | 1 | Latency mark |
| ring_ok | output | 1 | Ring-intact flag |
| err_pulse | output | 1 | Corrupt packet discarded |
| lat_valid | output | 1 | Latency result strobe |
| lat_cycles | output | LAT_W | Measured round-trip cycles |

## Verification
The bench targets the following corner cases:
- A relayable first beat arriving in the same cycle as local data. A design without the right priority would send the local packet first.
- Upstream beats and downstream ready toggling in the middle of packets. A design that does not hold the link for one packet would mix beats of two packets, which the beat-by-beat order check catches.
- Own and corrupt packets arriving while a local packet holds the link. These must still be drained, and a design that stalls them would block the ring.
- The timeout, checked on the exact edge where ring_ok falls.
- The latency counter, measured both for a short round trip and for one long enough to saturate. An off-by-one count or a wrapping counter would be visible in lat_cycles.

// File: rtl/ring_fwd_pkg.sv
package ring_fwd_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_FWD  = 2'd1,
    OWN_LOC  = 2'd2
  } owner_e;

  typedef enum logic [1:0] {
    RX_FWD   = 2'd0,
    RX_STRIP = 2'd1,
    RX_DROP  = 2'd2
  } rx_kind_e;
endpackage

// File: rtl/ring_rx_classify.sv
module ring_rx_classify
  import ring_fwd_pkg::*;
#(
  parameter int ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] node_id,
  input  logic            rx_valid,
  input  logic [ID_W-1:0] rx_src,
  input  logic            rx_err,
  input  logic            rx_last,
  input  logic            rx_fire,
  output logic            rx_head,
  output rx_kind_e        rx_kind
);
  logic     in_pkt_q, in_pkt_d;
  rx_kind_e kind_q, kind_d, head_kind;

  always_comb begin
    if (rx_err)                 head_kind = RX_DROP;
    else if (rx_src == node_id) head_kind = RX_STRIP;
    else                        head_kind = RX_FWD;
  end

  assign rx_head = !in_pkt_q;
  assign rx_kind = in_pkt_q ? kind_q : head_kind;

  always_comb begin
    in_pkt_d = in_pkt_q;
    kind_d   = kind_q;
    if (rx_fire) begin
      in_pkt_d = !rx_last;
      if (!in_pkt_q) kind_d = head_kind;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;
      kind_q   <= RX_FWD;
    end else begin
      in_pkt_q <= in_pkt_d;
      kind_q   <= kind_d;
    end
  end

  // R4: a discarded packet keeps its class until its last beat
  a_r4_kind_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_fire && !rx_last && rx_kind != RX_FWD) |=> (rx_kind != RX_FWD));
endmodule

// File: rtl/ring_tx_arbiter.sv
module ring_tx_arbiter
  import ring_fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   node_id,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [ID_W-1:0]   rx_src,
  input  logic              rx_last,
  input  logic              rx_mark,
  input  logic              rx_head,
  input  rx_kind_e          rx_kind,
  output logic              rx_ready,
  output logic              rx_fire,
  input  logic              loc_valid,
  input  logic [DATA_W-1:0] loc_data,
  input  logic              loc_last,
  input  logic              loc_mark,
  output logic              loc_ready,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic [ID_W-1:0]   tx_src,
  output logic              tx_last,
  output logic              tx_mark,
  output logic              loc_head_fire,
  output logic              loc_head_mark,
  output logic              own_ret_fire,
  output logic              own_ret_mark,
  output logic              err_head_fire
);
  owner_e own_q, own_d, sel;
  logic   loc_in_q, loc_in_d;
  logic   fwd_beat, loc_fire;

  assign fwd_beat = rx_valid && (rx_kind == RX_FWD);

  // Owner: a started packet keeps the link; otherwise relayed traffic first
  always_comb begin
    case (own_q)
      OWN_FWD: sel = OWN_FWD;
      OWN_LOC: sel = OWN_LOC;
      default: sel = fwd_beat ? OWN_FWD : (loc_valid ? OWN_LOC : OWN_NONE);
    endcase
  end

  always_comb begin
    tx_valid = 1'b0;
    tx_data  = loc_data;
    tx_src   = node_id;
    tx_last  = loc_last;
    tx_mark  = loc_mark;
    if (sel == OWN_FWD) begin
      tx_valid = rx_valid;
      tx_data  = rx_data;
      tx_src   = rx_src;
      tx_last  = rx_last;
      tx_mark  = rx_mark;
    end else if (sel == OWN_LOC) begin
      tx_valid = loc_valid;
    end
  end

  assign rx_ready  = (rx_kind != RX_FWD) || ((sel == OWN_FWD) && tx_ready);
  assign loc_ready = (sel == OWN_LOC) && tx_ready;
  assign rx_fire   = rx_valid && rx_ready;
  assign loc_fire  = loc_valid && loc_ready;

  assign loc_head_fire = loc_fire && !loc_in_q;
  assign loc_head_mark = loc_mark;
  assign own_ret_fire  = rx_fire && rx_head && (rx_kind == RX_STRIP);
  assign own_ret_mark  = rx_mark;
  assign err_head_fire = rx_fire && rx_head && (rx_kind == RX_DROP);

  always_comb begin
    own_d = own_q;
    if (tx_valid) own_d = (tx_ready && tx_last) ? OWN_NONE : sel;
    loc_in_d = loc_in_q;
    if (loc_fire) loc_in_d = !loc_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q    <= OWN_NONE;
      loc_in_q <= 1'b0;
    end else begin
      own_q    <= own_d;
      loc_in_q <= loc_in_d;
    end
  end

  a_r5_relay_first: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_NONE && rx_valid && rx_head && rx_kind == RX_FWD)
      |-> (tx_valid && !loc_ready && tx_src == rx_src));
  a_r6_loc_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_LOC) |-> !(rx_valid && rx_ready && rx_kind == RX_FWD));
  a_r6_fwd_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_FWD) |-> !loc_ready);
  a_r6_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (own_q != OWN_NONE));
  a_r3_no_own_relay: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_head && rx_ready && rx_kind == RX_FWD) |-> (tx_src != node_id));
endmodule

// File: rtl/ring_monitor.sv
module ring_monitor #(
  parameter int TO_W  = 16,
  parameter int LAT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TO_W-1:0]  timeout_cfg,
  input  logic             loc_head_fire,
  input  logic             loc_head_mark,
  input  logic             own_ret_fire,
  input  logic             own_ret_mark,
  input  logic             err_head_fire,
  output logic             ring_ok,
  output logic             err_pulse,
  output logic             lat_valid,
  output logic [LAT_W-1:0] lat_cycles
);
  localparam logic [LAT_W-1:0] LAT_MAX = {LAT_W{1'b1}};
  localparam logic [LAT_W-1:0] LAT_ONE = LAT_W'(1);
  localparam logic [TO_W-1:0]  TO_ONE  = TO_W'(1);

  logic             ok_q, ok_d, armed_q, armed_d, err_q, err_d;
  logic [TO_W-1:0]  to_q, to_d;
  logic             run_q, run_d, lv_q, lv_d;
  logic [LAT_W-1:0] lc_q, lc_d, lo_q, lo_d, lat_inc;

  assign lat_inc = (lc_q == LAT_MAX) ? LAT_MAX : (lc_q + LAT_ONE);

  always_comb begin
    ok_d    = ok_q;
    armed_d = armed_q;
    to_d    = to_q;
    if (own_ret_fire) ok_d = 1'b1;
    if (loc_head_fire) begin
      armed_d = 1'b1;
      to_d    = '0;
    end else if (own_ret_fire) begin
      armed_d = 1'b0;
    end else if (armed_q) begin
      if (to_q == timeout_cfg) begin
        ok_d    = 1'b0;
        armed_d = 1'b0;
      end else begin
        to_d = to_q + TO_ONE;
      end
    end
  end

  always_comb begin
    run_d = run_q;
    lc_d  = lc_q;
    lv_d  = 1'b0;
    lo_d  = lo_q;
    if (loc_head_fire && loc_head_mark) begin
      run_d = 1'b1;
      lc_d  = '0;
    end else if (run_q) begin
      if (own_ret_fire && own_ret_mark) begin
        run_d = 1'b0;
        lv_d  = 1'b1;
        lo_d  = lat_inc;
      end else begin
        lc_d = lat_inc;
      end
    end
    err_d = err_head_fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q    <= 1'b0;
      armed_q <= 1'b0;
      to_q    <= '0;
      run_q   <= 1'b0;
      lc_q    <= '0;
      lv_q    <= 1'b0;
      lo_q    <= '0;
      err_q   <= 1'b0;
    end else begin
      ok_q    <= ok_d;
      armed_q <= armed_d;
      to_q    <= to_d;
      run_q   <= run_d;
      lc_q    <= lc_d;
      lv_q    <= lv_d;
      lo_q    <= lo_d;
      err_q   <= err_d;
    end
  end

  assign ring_ok    = ok_q;
  assign err_pulse  = err_q;
  assign lat_valid  = lv_q;
  assign lat_cycles = lo_q;

  a_r8_ok_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ok_q) |-> $past(own_ret_fire));
  a_r9_ok_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ok_q) |-> $past(armed_q && !own_ret_fire && !loc_head_fire));
  a_r4_err_once: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(err_head_fire));
  a_r10_lat_cause: assert property (@(posedge clk) disable iff (!rst_n)
    lv_q |-> ($past(own_ret_fire && own_ret_mark) && lo_q != '0));
endmodule

// File: rtl/ring_fwd_arbiter.sv
module ring_fwd_arbiter
  import ring_fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ID_W   = 8,
  parameter int TO_W   = 16,
  parameter int LAT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   node_id,
  input  logic [TO_W-1:0]   timeout_cfg,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [ID_W-1:0]   rx_src,
  input  logic              rx_last,
  input  logic              rx_err,
  input  logic              rx_mark,
  input  logic              loc_valid,
  output logic              loc_ready,
  input  logic [DATA_W-1:0] loc_data,
  input  logic              loc_last,
  input  logic              loc_mark,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic [ID_W-1:0]   tx_src,
  output logic              tx_last,
  output logic              tx_mark,
  output logic              ring_ok,
  output logic              err_pulse,
  output logic              lat_valid,
  output logic [LAT_W-1:0]  lat_cycles
);
  logic     rx_head, rx_fire;
  rx_kind_e rx_kind;
  logic     loc_head_fire, loc_head_mark, own_ret_fire, own_ret_mark, err_head_fire;

  ring_rx_classify #(.ID_W(ID_W)) u_cls (
    .clk(clk), .rst_n(rst_n), .node_id(node_id),
    .rx_valid(rx_valid), .rx_src(rx_src), .rx_err(rx_err), .rx_last(rx_last),
    .rx_fire(rx_fire), .rx_head(rx_head), .rx_kind(rx_kind)
  );

  ring_tx_arbiter #(.DATA_W(DATA_W), .ID_W(ID_W)) u_arb (
    .clk(clk), .rst_n(rst_n), .node_id(node_id),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_src(rx_src), .rx_last(rx_last),
    .rx_mark(rx_mark), .rx_head(rx_head), .rx_kind(rx_kind),
    .rx_ready(rx_ready), .rx_fire(rx_fire),
    .loc_valid(loc_valid), .loc_data(loc_data), .loc_last(loc_last),
    .loc_mark(loc_mark), .loc_ready(loc_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_src(tx_src),
    .tx_last(tx_last), .tx_mark(tx_mark),
    .loc_head_fire(loc_head_fire), .loc_head_mark(loc_head_mark),
    .own_ret_fire(own_ret_fire), .own_ret_mark(own_ret_mark),
    .err_head_fire(err_head_fire)
  );

  ring_monitor #(.TO_W(TO_W), .LAT_W(LAT_W)) u_mon (
    .clk(clk), .rst_n(rst_n), .timeout_cfg(timeout_cfg),
    .loc_head_fire(loc_head_fire), .loc_head_mark(loc_head_mark),
    .own_ret_fire(own_ret_fire), .own_ret_mark(own_ret_mark),
    .err_head_fire(err_head_fire),
    .ring_ok(ring_ok), .err_pulse(err_pulse),
    .lat_valid(lat_valid), .lat_cycles(lat_cycles)
  );

  // R1: nothing leaves the block while no input is offered
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !loc_valid) |-> !tx_valid);
endmodule

// File: tb/sim_ring_fwd_arbiter.sv
module sim_ring_fwd_arbiter;
  localparam int DW = 32, IW = 8, TW = 16, LW = 6;
  localparam logic [IW-1:0] NODE = 8'h5A;
  localparam int LMAX = (1 << LW) - 1;

  typedef struct packed {
    logic [DW-1:0] data;
    logic [IW-1:0] src;
    logic last, err, mark;
  } beat_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [TW-1:0] timeout_cfg;
  logic rx_valid, rx_ready, rx_last, rx_err, rx_mark;
  logic [DW-1:0] rx_data;
  logic [IW-1:0] rx_src;
  logic loc_valid, loc_ready, loc_last, loc_mark;
  logic [DW-1:0] loc_data;
  logic tx_valid, tx_ready, tx_last, tx_mark;
  logic [DW-1:0] tx_data;
  logic [IW-1:0] tx_src;
  logic ring_ok, err_pulse, lat_valid;
  logic [LW-1:0] lat_cycles;

  always #2 clk = ~clk;

  ring_fwd_arbiter #(.DATA_W(DW), .ID_W(IW), .TO_W(TW), .LAT_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .node_id(NODE), .timeout_cfg(timeout_cfg),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_src(rx_src),
    .rx_last(rx_last), .rx_err(rx_err), .rx_mark(rx_mark),
    .loc_valid(loc_valid), .loc_ready(loc_ready), .loc_data(loc_data),
    .loc_last(loc_last), .loc_mark(loc_mark),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .tx_src(tx_src),
    .tx_last(tx_last), .tx_mark(tx_mark),
    .ring_ok(ring_ok), .err_pulse(err_pulse), .lat_valid(lat_valid),
    .lat_cycles(lat_cycles)
  );

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  beat_t rx_q[$], loc_q[$], exp_fwd[$], exp_loc[$];
  int  p_rx = 70, p_loc = 60, p_tx = 70;
  int  b_owner = 0, b_rx_cls = 0;
  bit  b_rx_in = 0, b_loc_in = 0;
  bit  ok_exp = 0, chk_ok = 1, pend_err = 0, pend_lat = 0, lat_run = 0;
  int  pend_lat_val = 0, lat_s = 0;

  task automatic chk(bit good, string req, longint act, longint exp);
    n_cmp++;
    if (!good) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 relay, 1 own, 2 corrupt
  task automatic gen_rx(int kind, int len, bit mark);
    logic [IW-1:0] s;
    s = 8'($urandom);
    if (s == NODE) s = s ^ 8'h01;
    if (kind == 1) s = NODE;
    for (int i = 0; i < len; i++) begin
      beat_t b;
      b.data = $urandom; b.src = s; b.last = (i == len - 1);
      b.err = (i == 0) ? (kind == 2) : 1'($urandom);
      b.mark = mark;
      rx_q.push_back(b);
      if (kind == 0) exp_fwd.push_back(b);
    end
  endtask

  task automatic gen_loc(int len, bit mark);
    for (int i = 0; i < len; i++) begin
      beat_t b;
      b.data = $urandom; b.src = NODE; b.last = (i == len - 1);
      b.err = 1'b0; b.mark = mark;
      loc_q.push_back(b);
      exp_loc.push_back(b);
    end
  endtask

  task automatic step();
    bit rv, lv, head, send_m, ret_m;
    int cls;
    beat_t e;
    @(negedge clk);
    chk(err_pulse == pend_err, "R4 err_pulse", err_pulse, pend_err);
    chk(lat_valid == pend_lat, "R10 lat_valid", lat_valid, pend_lat);
    if (pend_lat) chk(lat_cycles == LW'(pend_lat_val), "R10 lat_cycles", lat_cycles, pend_lat_val);
    if (chk_ok) chk(ring_ok == ok_exp, "R8 ring_ok", ring_ok, ok_exp);
    pend_err = 0; pend_lat = 0;
    rv = (rx_q.size() > 0) && (($urandom % 100) < p_rx);
    lv = (loc_q.size() > 0) && (($urandom % 100) < p_loc);
    rx_valid = rv;
    if (rx_q.size() > 0) begin
      rx_data = rx_q[0].data; rx_src = rx_q[0].src; rx_last = rx_q[0].last;
      rx_err = rx_q[0].err; rx_mark = rx_q[0].mark;
    end
    loc_valid = lv;
    if (loc_q.size() > 0) begin
      loc_data = loc_q[0].data; loc_last = loc_q[0].last; loc_mark = loc_q[0].mark;
    end
    tx_ready = (($urandom % 100) < p_tx);
    #1;
    head = !b_rx_in;
    cls = b_rx_cls;
    if (head && rv) cls = rx_err ? 2 : ((rx_src == NODE) ? 1 : 0);
    if (rv && cls == 0 && b_owner == 0)
      chk(tx_valid && !loc_ready && tx_src == rx_src, "R5 relay wins", tx_src, rx_src);
    if (rv && cls == 0 && b_owner == 2) chk(!rx_ready, "R6 relay held off", rx_ready, 0);
    if (b_owner == 1) chk(!loc_ready, "R6 local held off", loc_ready, 0);
    if (rv && cls != 0) chk(rx_ready, "R3 discard accepted", rx_ready, 1);
    if (b_owner != 0 && tx_valid)
      chk((b_owner == 2) == (tx_src == NODE), "R6 packet kept", tx_src, b_owner);
    if (tx_valid && tx_ready) begin
      if (tx_src == NODE) begin
        if (exp_loc.size() == 0) chk(0, "R7 unexpected local", tx_data, 0);
        else begin
          e = exp_loc.pop_front();
          chk({tx_data, tx_src, tx_last, tx_mark} == {e.data, e.src, e.last, e.mark},
              "R7 local beat", tx_data, e.data);
        end
      end else begin
        if (exp_fwd.size() == 0) chk(0, "R2 unexpected relay", tx_data, 0);
        else begin
          e = exp_fwd.pop_front();
          chk({tx_data, tx_src, tx_last, tx_mark} == {e.data, e.src, e.last, e.mark},
              "R2 relay beat", tx_data, e.data);
        end
      end
      b_owner = tx_last ? 0 : ((tx_src == NODE) ? 2 : 1);
    end else if (tx_valid) begin
      b_owner = (tx_src == NODE) ? 2 : 1;
    end
    send_m = 0; ret_m = 0;
    if (rv && rx_ready) begin
      if (head) begin
        b_rx_cls = cls;
        if (cls == 2) pend_err = 1;
        if (cls == 1) begin ok_exp = 1; ret_m = rx_mark; end
      end
      b_rx_in = !rx_last;
      void'(rx_q.pop_front());
    end
    if (lv && loc_ready) begin
      if (!b_loc_in && loc_mark) send_m = 1;
      b_loc_in = !loc_last;
      void'(loc_q.pop_front());
    end
    if (send_m) begin lat_run = 1; lat_s = cyc; end
    else if (lat_run && ret_m) begin
      lat_run = 0; pend_lat = 1;
      pend_lat_val = ((cyc - lat_s) > LMAX) ? LMAX : (cyc - lat_s);
    end
  endtask

  task automatic drain();
    int guard = 0;
    while ((rx_q.size() > 0 || loc_q.size() > 0 || b_owner != 0) && guard < 500) begin
      step(); guard++;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    timeout_cfg = '1;
    rx_valid = 0; rx_data = '0; rx_src = '0; rx_last = 0; rx_err = 0; rx_mark = 0;
    loc_valid = 0; loc_data = '0; loc_last = 0; loc_mark = 0; tx_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!tx_valid && !ring_ok && !err_pulse && !lat_valid, "R1 reset state",
        {tx_valid, ring_ok, err_pulse, lat_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !ring_ok && !lat_valid, "R1 after release", {tx_valid, ring_ok}, 0);

    // directed: relay head and local data in the same cycle
    p_rx = 100; p_loc = 100; p_tx = 100;
    gen_loc(2, 0); gen_rx(0, 3, 0);
    drain();
    // directed: corrupt and own packets while a local packet holds the link
    p_tx = 30;
    gen_loc(4, 0); gen_rx(2, 2, 0); gen_rx(1, 2, 0);
    drain();

    // random mix
    p_rx = 70; p_loc = 60; p_tx = 70;
    for (int n = 0; n < 3000; n++) begin
      if (rx_q.size() < 6) gen_rx(($urandom % 10 < 6) ? 0 : (($urandom % 2) ? 1 : 2),
                                  1 + $urandom % 4, 1'($urandom % 4 == 0));
      if (loc_q.size() < 6 && ($urandom % 3 == 0))
        gen_loc(1 + $urandom % 4, 1'($urandom % 4 == 0));
      step();
    end
    p_rx = 100; p_loc = 100; p_tx = 100;
    drain();
    chk(exp_fwd.size() == 0, "R2 all relayed", exp_fwd.size(), 0);
    chk(exp_loc.size() == 0, "R7 all sent", exp_loc.size(), 0);

    // R10: short round trip and saturated round trip
    gen_loc(2, 1); drain();
    repeat (7) step();
    gen_rx(1, 1, 1); drain(); step();
    gen_loc(1, 1); drain();
    repeat (80) step();
    gen_rx(1, 2, 1); drain(); step();

    // R9: timeout edge
    gen_rx(1, 1, 0); drain(); step();
    chk(ring_ok == 1, "R8 ring_ok before timeout", ring_ok, 1);
    chk_ok = 0;
    timeout_cfg = 16'd20;
    gen_loc(1, 0);
    while (loc_q.size() > 0) step();
    for (int i = 1; i <= 22; i++) begin
      step();
      if (i == 21) chk(ring_ok == 1, "R9 still set at T", ring_ok, 1);
      if (i == 22) chk(ring_ok == 0, "R9 cleared at T+1", ring_ok, 0);
    end
    gen_rx(1, 1, 0); drain(); step();
    chk(ring_ok == 1, "R8 ring_ok restored", ring_ok, 1);
    ok_exp = 1; chk_ok = 1;
    repeat (3) step();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule